// File: doc/BRIEF.md
# Snooping Four-State Line Coherence Controller

This block keeps the coherence state of the lines of one write-back, write-allocate cache that sits on a shared snooping bus. A small direct-mapped tag/state array holds, for each line, a tag and one of four states: Invalid, Exclusive (clean, sole copy), Shared (clean, other copies possible) and Modified (dirty, sole copy). The processor side presents single read or write requests. Hits on Exclusive or Modified lines finish locally. Misses and writes to Shared lines must first win the bus.

On the snoop side the block watches the transactions of other caches: read misses, write misses and invalidations. It updates any matching line, and it says in the same cycle whether it holds the line, whether it will drive the line's data, and whether that data also has to go back to memory. Misses are not atomic. Between issuing a request and receiving the fill, the line is parked as Invalid and the miss address is held in a pending register. A snoop to that address discards the fill in progress and restarts the request. At most one miss is outstanding at a time.

A line address of `ADDR_W` bits is split into an index (its low `log2(LINES)` bits) and a tag (the remaining upper bits). Bus command codes on `bus_cmd_o` and `snp_cmd_i` are 0 none, 1 read miss, 2 write miss and 3 invalidate.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req_o` and `cpu_done_o` are low, `cpu_ready_o` is high, and a snooped read to any address leaves `snp_shared_o` low.
- R2: A read miss ends, on the cycle `bus_fill_i` is high, in Exclusive if `bus_shared_i` is low and in Shared if it is high. `cpu_done_o` pulses on the following cycle.
- R3: A read hit on any valid line, or a write hit on an Exclusive or Modified line, completes with `cpu_done_o` on the next cycle and raises no bus request. A write hit leaves the line Modified.
- R4: A write hit on a Shared line requests the bus. In the grant cycle it drives command 3 (invalidate) with the line address, then becomes Modified, with `cpu_done_o` on the next cycle.
- R5: A write miss drives command 2 in its grant cycle. The line becomes Modified when the fill arrives.
- R6: A snooped read (command 1) whose index and tag match a valid line raises `snp_shared_o` and `snp_supply_o` in the same cycle. Exclusive and Modified lines then become Shared, and Shared lines stay Shared. A tag mismatch or an Invalid line raises neither output.
- R7: A snooped write miss or invalidate matching a valid line makes it Invalid. `snp_supply_o` is raised only if that line was Modified.
- R8: A snooped read that matches a Modified line also raises `snp_wb_o`, so memory is updated in the same transaction.
- R9: `bus_req_o` stays high from the acceptance of a request until `bus_gnt_i`. A command other than 0 is driven only in a cycle with `bus_gnt_i` high, and a read miss uses command 1.
- R10: When a miss is issued, its line is made Invalid under the new tag. `victim_wb_o` is raised in the issue cycle if the displaced line was Modified.
- R11: A snoop with any command to the pending address between issue and fill abandons the fill, and `bus_req_o` rises again the next cycle. The command is chosen again at the next grant, so a write to a Shared line that was invalidated before its grant issues command 2.
- R12: `cpu_ready_o` is low while a request is pending and in any cycle with `snp_valid_i` high. A `cpu_req_i` in such a cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, taken when `cpu_ready_o` is high |
| cpu_write_i | input | 1 | Request is a write |
| cpu_addr_i | input | ADDR_W | Line address of the request |
| cpu_ready_o | output | 1 | Controller can accept a request this cycle |
| cpu_done_o | output | 1 | One-cycle pulse, request completed |
| bus_req_o | output | 1 | Bus arbitration request |
| bus_gnt_i | input | 1 | Bus granted this cycle |
| bus_cmd_o | output | 2 | Command driven in the grant cycle |
| bus_addr_o | output | ADDR_W | Address of the pending request |
| victim_wb_o | output | 1 | Displaced Modified line must be written back |
| bus_fill_i | input | 1 | Fill for the pending miss arrives |
| bus_shared_i | input | 1 | Another cache reported holding the filled line |
| snp_valid_i | input | 1 | Foreign bus transaction present |
| snp_cmd_i | input | 2 | Command of the foreign transaction |
| snp_addr_i | input | ADDR_W | Line address of the foreign transaction |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_supply_o | output | 1 | This cache offers to drive the line data |
| snp_wb_o | output | 1 | Supplied data must also update memory |

## Verification
The checker watches, on every cycle, how the bus interface behaves in time. It checks that commands appear only under grant, that the request is held until grant, that a dirty victim is flagged only when a miss is issued, and that an invalidate finishes the request on the next cycle. It also checks that the snoop outputs stay consistent with one another and that a snoop or a pending miss always blocks new processor requests. The state a line reaches (Exclusive versus Shared after a fill, the silent upgrade, invalidation by snoops, an abandoned fill and its retry, and an upgrade that turns into a write miss) shows only through sequences of operations. The bench's scenarios probe that state afterwards with snoops and processor hits.

// File: rtl/snoop_line_pkg.sv
package snoop_line_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_E = 2'd1, ST_S = 2'd2, ST_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_WR = 2'd2, CMD_INV = 2'd3} bus_cmd_e;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_WAIT_GNT = 2'd1, F_WAIT_FILL = 2'd2} miss_st_e;

  function automatic line_st_e snoop_next(input line_st_e cur, input bus_cmd_e cmd);
    if (cmd == CMD_RD) return (cur == ST_I) ? ST_I : ST_S;
    if (cmd == CMD_WR || cmd == CMD_INV) return ST_I;
    return cur;
  endfunction
endpackage

// File: rtl/snoop_line_array.sv
module snoop_line_array
  import snoop_line_pkg::*;
#(
  parameter int LINES = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] cpu_idx_i,
  output line_st_e         cpu_st_o,
  output logic [TAG_W-1:0] cpu_tag_o,
  input  logic [IDX_W-1:0] snp_idx_i,
  output line_st_e         snp_st_o,
  output logic [TAG_W-1:0] snp_tag_o,
  input  logic             snp_we_i,
  input  line_st_e         snp_st_i,
  input  logic             cpu_we_i,
  input  logic [TAG_W-1:0] cpu_tag_i,
  input  line_st_e         cpu_wst_i
);
  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g]  <= ST_I;
        tag_q[g] <= '0;
      end else if (snp_we_i && snp_idx_i == IDX_W'(g)) begin
        st_q[g] <= snp_st_i;
      end else if (cpu_we_i && cpu_idx_i == IDX_W'(g)) begin
        st_q[g]  <= cpu_wst_i;
        tag_q[g] <= cpu_tag_i;
      end
    end
  end

  assign cpu_st_o  = st_q[cpu_idx_i];
  assign cpu_tag_o = tag_q[cpu_idx_i];
  assign snp_st_o  = st_q[snp_idx_i];
  assign snp_tag_o = tag_q[snp_idx_i];
endmodule

// File: rtl/snoop_resp_unit.sv
module snoop_resp_unit
  import snoop_line_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             snp_valid_i,
  input  bus_cmd_e         snp_cmd_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  line_st_e         line_st_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output logic             upd_we_o,
  output line_st_e         upd_st_o,
  output logic             shared_o,
  output logic             supply_o,
  output logic             wb_o
);
  logic hit;

  always_comb begin
    hit      = snp_valid_i && line_st_i != ST_I && line_tag_i == snp_tag_i;
    upd_we_o = hit && snp_cmd_i != CMD_NONE;
    upd_st_o = snoop_next(line_st_i, snp_cmd_i);
    shared_o = hit && snp_cmd_i == CMD_RD;
    // a dirty owner must hand its data to a foreign writer too
    supply_o = shared_o || (hit && snp_cmd_i == CMD_WR && line_st_i == ST_M);
    wb_o     = shared_o && line_st_i == ST_M;
  end
endmodule

// File: rtl/snoop_miss_fsm.sv
module snoop_miss_fsm
  import snoop_line_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_write_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_ready_o,
  output logic              cpu_done_o,
  input  logic              snp_valid_i,
  input  bus_cmd_e          snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output bus_cmd_e          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              victim_wb_o,
  input  logic              bus_fill_i,
  input  logic              bus_shared_i,
  output logic [IDX_W-1:0]  look_idx_o,
  input  line_st_e          look_st_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  output logic              wr_en_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output line_st_e          wr_st_o
);
  miss_st_e          st_q, st_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d, cur_addr;
  logic              pend_wr_q, pend_wr_d, done_d, tag_hit, abort;

  always_comb begin
    cur_addr    = (st_q == F_IDLE) ? cpu_addr_i : pend_addr_q;
    look_idx_o  = cur_addr[IDX_W-1:0];
    wr_tag_o    = cur_addr[ADDR_W-1:IDX_W];
    tag_hit     = look_st_i != ST_I && look_tag_i == wr_tag_o;
    abort       = snp_valid_i && snp_cmd_i != CMD_NONE && snp_addr_i == pend_addr_q;
    cpu_ready_o = st_q == F_IDLE && !snp_valid_i;
    bus_req_o   = st_q == F_WAIT_GNT;
    bus_addr_o  = pend_addr_q;
    st_d        = st_q;
    pend_addr_d = pend_addr_q;
    pend_wr_d   = pend_wr_q;
    wr_en_o     = 1'b0;
    wr_st_o     = ST_I;
    done_d      = 1'b0;
    bus_cmd_o   = CMD_NONE;
    victim_wb_o = 1'b0;
    case (st_q)
      F_IDLE: if (cpu_req_i && cpu_ready_o) begin
        if (tag_hit && !cpu_write_i) begin
          done_d = 1'b1;
        end else if (tag_hit && look_st_i != ST_S) begin
          wr_en_o = 1'b1;
          wr_st_o = ST_M;
          done_d  = 1'b1;
        end else begin
          pend_addr_d = cpu_addr_i;
          pend_wr_d   = cpu_write_i;
          st_d        = F_WAIT_GNT;
        end
      end
      F_WAIT_GNT: if (bus_gnt_i) begin
        // command chosen at grant: a snoop may have invalidated a Shared copy meanwhile
        if (tag_hit && pend_wr_q) begin
          bus_cmd_o = CMD_INV;
          wr_en_o   = 1'b1;
          wr_st_o   = ST_M;
          done_d    = 1'b1;
          st_d      = F_IDLE;
        end else begin
          bus_cmd_o   = pend_wr_q ? CMD_WR : CMD_RD;
          victim_wb_o = look_st_i == ST_M;
          wr_en_o     = 1'b1;
          wr_st_o     = ST_I;
          st_d        = F_WAIT_FILL;
        end
      end
      F_WAIT_FILL: begin
        if (abort) begin
          st_d = F_WAIT_GNT;
        end else if (bus_fill_i) begin
          wr_en_o = 1'b1;
          wr_st_o = pend_wr_q ? ST_M : (bus_shared_i ? ST_S : ST_E);
          done_d  = 1'b1;
          st_d    = F_IDLE;
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= F_IDLE;
      pend_addr_q <= '0;
      pend_wr_q   <= 1'b0;
      cpu_done_o  <= 1'b0;
    end else begin
      st_q        <= st_d;
      pend_addr_q <= pend_addr_d;
      pend_wr_q   <= pend_wr_d;
      cpu_done_o  <= done_d;
    end
  end
endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl
  import snoop_line_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_write_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_ready_o,
  output logic              cpu_done_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              victim_wb_o,
  input  logic              bus_fill_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic              snp_wb_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  bus_cmd_e         snp_cmd, cmd;
  line_st_e         look_st, snp_line_st, upd_st, wr_st;
  logic [TAG_W-1:0] look_tag, snp_line_tag, wr_tag;
  logic [IDX_W-1:0] look_idx;
  logic             upd_we, wr_en;

  assign snp_cmd   = bus_cmd_e'(snp_cmd_i);
  assign bus_cmd_o = cmd;

  snoop_line_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_array (
    .clk_i, .rst_ni,
    .cpu_idx_i (look_idx),
    .cpu_st_o  (look_st),
    .cpu_tag_o (look_tag),
    .snp_idx_i (snp_addr_i[IDX_W-1:0]),
    .snp_st_o  (snp_line_st),
    .snp_tag_o (snp_line_tag),
    .snp_we_i  (upd_we),
    .snp_st_i  (upd_st),
    .cpu_we_i  (wr_en),
    .cpu_tag_i (wr_tag),
    .cpu_wst_i (wr_st)
  );

  snoop_resp_unit #(.TAG_W(TAG_W)) i_resp (
    .snp_valid_i,
    .snp_cmd_i  (snp_cmd),
    .snp_tag_i  (snp_addr_i[ADDR_W-1:IDX_W]),
    .line_st_i  (snp_line_st),
    .line_tag_i (snp_line_tag),
    .upd_we_o   (upd_we),
    .upd_st_o   (upd_st),
    .shared_o   (snp_shared_o),
    .supply_o   (snp_supply_o),
    .wb_o       (snp_wb_o)
  );

  snoop_miss_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_fsm (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_write_i, .cpu_addr_i, .cpu_ready_o, .cpu_done_o,
    .snp_valid_i,
    .snp_cmd_i  (snp_cmd),
    .snp_addr_i,
    .bus_req_o, .bus_gnt_i,
    .bus_cmd_o  (cmd),
    .bus_addr_o, .victim_wb_o, .bus_fill_i, .bus_shared_i,
    .look_idx_o (look_idx),
    .look_st_i  (look_st),
    .look_tag_i (look_tag),
    .wr_en_o    (wr_en),
    .wr_tag_o   (wr_tag),
    .wr_st_o    (wr_st)
  );
endmodule

// File: rtl/snoop_line_ctrl_chk.sv
module snoop_line_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpu_ready_o,
  input logic       cpu_done_o,
  input logic       bus_req_o,
  input logic       bus_gnt_i,
  input logic [1:0] bus_cmd_o,
  input logic       victim_wb_o,
  input logic       snp_valid_i,
  input logic       snp_shared_o,
  input logic       snp_supply_o,
  input logic       snp_wb_o
);
  a_r9_cmd_in_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != 2'd0) |-> bus_gnt_i);
  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o);
  a_r12_snoop_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !cpu_ready_o);
  a_r12_pending_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !cpu_ready_o);
  a_r6_shared_supplies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_shared_o |-> snp_supply_o);
  a_r8_wb_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_wb_o |-> (snp_shared_o && snp_supply_o));
  a_r10_victim_at_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_wb_o |-> (bus_cmd_o == 2'd1 || bus_cmd_o == 2'd2));
  a_r4_inv_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == 2'd3) |=> cpu_done_o);
endmodule

bind snoop_line_ctrl snoop_line_ctrl_chk i_chk (
  .clk_i, .rst_ni, .cpu_ready_o, .cpu_done_o, .bus_req_o, .bus_gnt_i,
  .bus_cmd_o, .victim_wb_o, .snp_valid_i, .snp_shared_o, .snp_supply_o, .snp_wb_o
);

// File: tb/test_snoop_line_ctrl.sv
`timescale 1ns/1ps
module test_snoop_line_ctrl;
  localparam int AW = 8;
  localparam logic [1:0] C_RD = 2'd1, C_WR = 2'd2, C_INV = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_write = 0, bus_gnt = 0, bus_fill = 0, bus_shared = 0, snp_valid = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [1:0] snp_cmd = '0;
  logic cpu_ready, cpu_done, bus_req, victim_wb, snp_shared, snp_supply, snp_wb;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  snoop_line_ctrl #(.ADDR_W(AW), .LINES(4)) i_snoop_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_write_i(cpu_write), .cpu_addr_i(cpu_addr),
    .cpu_ready_o(cpu_ready), .cpu_done_o(cpu_done),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .victim_wb_o(victim_wb), .bus_fill_i(bus_fill), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared), .snp_supply_o(snp_supply), .snp_wb_o(snp_wb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // all tasks start and end just after a negative edge
  task automatic cpu_access(input logic [AW-1:0] a, input logic wr);
    cpu_req = 1; cpu_addr = a; cpu_write = wr;
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic grant(input string req, input logic [1:0] ecmd, input logic [AW-1:0] ea, input logic ev);
    check({req, " request before grant"}, 32'(bus_req), 1);
    bus_gnt = 1;
    #1;
    check({req, " command"}, 32'(bus_cmd), 32'(ecmd));
    check({req, " address"}, 32'(bus_addr), 32'(ea));
    check({req, " victim"}, 32'(victim_wb), 32'(ev));
    @(negedge clk);
    bus_gnt = 0;
  endtask

  task automatic fill(input string req, input logic sh);
    bus_fill = 1; bus_shared = sh;
    @(negedge clk);
    bus_fill = 0; bus_shared = 0;
    check({req, " done after fill"}, 32'(cpu_done), 1);
  endtask

  task automatic snoop(input string req, input logic [1:0] c, input logic [AW-1:0] a,
                       input logic esh, input logic esu, input logic ewb);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1;
    check({req, " shared"}, 32'(snp_shared), 32'(esh));
    check({req, " supply"}, 32'(snp_supply), 32'(esu));
    check({req, " writeback"}, 32'(snp_wb), 32'(ewb));
    @(negedge clk);
    snp_valid = 0; snp_cmd = '0;
  endtask

  task automatic t_reset;
    check("R1 no request", 32'(bus_req), 0);
    check("R1 ready", 32'(cpu_ready), 1);
    check("R1 no done", 32'(cpu_done), 0);
    snoop("R1 empty array", C_RD, 8'h10, 0, 0, 0);
  endtask

  task automatic t_exclusive_flow;
    cpu_access(8'h21, 0);
    grant("R9 read miss", C_RD, 8'h21, 0);
    check("R9 request dropped after grant", 32'(bus_req), 0);
    fill("R2 exclusive", 0);
    cpu_access(8'h21, 1);
    check("R3 silent write done", 32'(cpu_done), 1);
    check("R3 silent write no bus", 32'(bus_req), 0);
    snoop("R8 modified read snoop", C_RD, 8'h21, 1, 1, 1);
    cpu_access(8'h21, 1);
    check("R4 shared write needs bus", 32'(bus_req), 1);
    check("R4 not done yet", 32'(cpu_done), 0);
    grant("R4 upgrade", C_INV, 8'h21, 0);
    check("R4 done after invalidate", 32'(cpu_done), 1);
    snoop("R4 line now modified", C_RD, 8'h21, 1, 1, 1);
  endtask

  task automatic t_shared_fill;
    cpu_access(8'h32, 0);
    grant("R2 read miss", C_RD, 8'h32, 0);
    fill("R2 shared", 1);
    snoop("R6 shared line read snoop", C_RD, 8'h32, 1, 1, 0);
    cpu_access(8'h32, 0);
    check("R3 read hit done", 32'(cpu_done), 1);
    check("R3 read hit no bus", 32'(bus_req), 0);
    snoop("R6 other tag same index", C_RD, 8'h36, 0, 0, 0);
    snoop("R7 invalidate shared", C_INV, 8'h32, 0, 0, 0);
    snoop("R7 line gone", C_RD, 8'h32, 0, 0, 0);
  endtask

  task automatic t_write_miss;
    cpu_access(8'h43, 1);
    grant("R5 write miss", C_WR, 8'h43, 0);
    fill("R5 modified", 0);
    snoop("R7 write snoop on modified", C_WR, 8'h43, 0, 1, 0);
    snoop("R7 invalidated", C_RD, 8'h43, 0, 0, 0);
  endtask

  task automatic t_evict;
    cpu_access(8'h05, 1);
    grant("R10 clean victim", C_WR, 8'h05, 0);
    fill("R5 write fill", 0);
    cpu_access(8'h09, 0);
    grant("R10 dirty victim", C_RD, 8'h09, 1);
    fill("R2 refill", 0);
    snoop("R10 displaced tag", C_RD, 8'h05, 0, 0, 0);
  endtask

  task automatic t_abort;
    cpu_access(8'h50, 0);
    grant("R11 first try", C_RD, 8'h50, 0);
    snoop("R10 pending line invalid", C_WR, 8'h50, 0, 0, 0);
    check("R11 retry requested", 32'(bus_req), 1);
    check("R11 no done on abort", 32'(cpu_done), 0);
    grant("R11 retry", C_RD, 8'h50, 0);
    fill("R11 retry fill", 0);
    snoop("R11 exclusive after retry", C_RD, 8'h50, 1, 1, 0);
  endtask

  task automatic t_lost_upgrade;
    cpu_access(8'h60, 0);
    grant("R2 miss", C_RD, 8'h60, 0);
    fill("R2 shared", 1);
    cpu_access(8'h60, 1);
    snoop("R7 invalidated before grant", C_WR, 8'h60, 0, 0, 0);
    grant("R11 upgrade becomes write miss", C_WR, 8'h60, 0);
    fill("R11 write fill", 0);
    snoop("R11 line modified", C_RD, 8'h60, 1, 1, 1);
  endtask

  task automatic t_busy;
    snp_valid = 1; snp_cmd = C_RD; snp_addr = 8'hFF;
    #1;
    check("R12 snoop blocks ready", 32'(cpu_ready), 0);
    @(negedge clk);
    snp_valid = 0; snp_cmd = '0;
    cpu_access(8'h74, 0);
    check("R12 pending blocks ready", 32'(cpu_ready), 0);
    grant("R10 shared victim", C_RD, 8'h74, 0);
    cpu_access(8'h11, 0);
    fill("R12 only fill", 0);
    @(negedge clk);
    check("R12 ignored request no bus", 32'(bus_req), 0);
    check("R12 ignored request no done", 32'(cpu_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_exclusive_flow();
    t_shared_fill();
    t_write_miss();
    t_evict();
    t_abort();
    t_lost_upgrade();
    t_busy();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule